// File: doc/BRIEF.md
# Profile-Driven Masked Register Streamer

This block is a memory-mapped control slave that sits in front of a small bank of target configuration registers, which are replicated once per channel. It holds eight fixed configuration profiles. Each profile is a list of entries, and each entry names a target register, an 8-bit bit-mask and an 8-bit value. When software writes the control word with the load bit set, the block walks through the chosen profile on its own. For every entry it applies one masked read-modify-write, so a reconfiguration changes only the bits that differ from the current setting, even when those bits are spread over many registers.

Software talks to the block over a word-addressed bus with read, write, read data and a wait request. It selects a profile, optionally asks for the update to reach every channel copy, sets the load bit, and then polls a busy flag until the stream is complete. While a stream runs, host accesses to the target registers are held off with the wait request. The control and status words stay readable at all times.

Top module: `prof_streamer`

## Requirements
- R1: After reset, the status word (0x341) reads 0x00 and the control word (0x340) reads 0x00. Target register r of every channel reads 0x55 XOR r.
- R2: A write to the control word at word address 0x340 while idle stores the profile number from bits [2:0] and the broadcast flag from bit 6. Reading 0x340 returns the profile in bits [2:0] and the broadcast flag in bit 6. Bit 7 (load) and all other bits read 0.
- R3: A control write while idle with bit 7 set starts a stream. Bit 0 of the status word (0x341) reads 1 from the next cycle for N+1 cycles, where N is the number of valid entries in the profile, and then reads 0. A control write with bit 7 clear starts nothing.
- R4: Each valid entry updates its target register to (old & ~mask) | (value & mask). Entries are applied one per cycle, in order.
- R5: Profile p has p valid entries, numbered e = 0..p-1. Entry e targets register (5p+7e) mod 64. Its mask is 0xF0 when e is odd and 0x3C when e is even. Its value is ((16p+3e+1) mod 256) XOR 0xA5. Profile 0 is empty.
- R6: With broadcast clear, a stream changes only the channel that was on host_ch during the load write.
- R7: With broadcast set, every entry is applied to all channel copies in the same cycle.
- R8: A write to 0x340 while busy is ignored. It starts no new stream and does not change the profile or broadcast readback.
- R9: While busy, a read or write of a target register (address below 64) sees host_waitreq = 1, and a held-off write is not applied. Accesses to 0x340 and 0x341 never see host_waitreq.
- R10: While idle, a host write to address a < 64 stores the data in register a of channel host_ch. A read returns that register in the same cycle.
- R11: Reads of any other address return 0x00, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 10 | Word address |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_ch | input | 2 | Channel selected for target accesses and for a non-broadcast stream |
| host_rdata | output | 8 | Read data, valid in the cycle of a read that is not held off |
| host_waitreq | output | 1 | High when the current access must be retried |

## Verification
Assertions check on every cycle that a host write never reaches the register bank during a stream, that stream and host addresses stay inside the bank, and that the profile, broadcast and channel captures hold while busy. They also check that a stream ends exactly at the first invalid entry, and that control and status reads are never held off. The bench's reference model is the only place the actual register contents are shown to be correct. Those contents cover the masked merge, which entries each profile holds, the difference between broadcast and single-channel streams, the busy duration of an empty profile, and the fact that a held-off write is dropped.

// File: rtl/pstream_pkg.sv
package pstream_pkg;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 8;
    localparam int PROF_W   = 3;
    localparam int MAX_ENT  = 8;
    localparam int ENT_W    = $clog2(MAX_ENT + 1);
    localparam int TGT_DEPTH = 64;
    localparam int NUM_CH   = 4;
    localparam int CH_W     = $clog2(NUM_CH);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 10'h340;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 10'h341;
    localparam int LOAD_BIT  = 7;
    localparam int BCAST_BIT = 6;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] val;
    } entry_t;

    function automatic entry_t profile_entry(input logic [PROF_W-1:0] p,
                                             input logic [ENT_W-1:0] e,
                                             input int depth);
        entry_t r;
        int pi;
        int ei;
        pi = int'(p);
        ei = int'(e);
        r.valid = (ei < pi) && (ei < MAX_ENT);
        r.addr  = ADDR_W'((5 * pi + 7 * ei) % depth);
        r.mask  = e[0] ? 8'hF0 : 8'h3C;
        r.val   = DATA_W'((16 * pi + 3 * ei + 1) % 256) ^ 8'hA5;
        return r;
    endfunction
endpackage

// File: rtl/profile_rom.sv
module profile_rom
    import pstream_pkg::*;
#(
    parameter int DEPTH = TGT_DEPTH
) (
    input  logic [PROF_W-1:0] prof,
    input  logic [ENT_W-1:0]  idx,
    output entry_t            entry
);
    assign entry = profile_entry(prof, idx, DEPTH);
endmodule

// File: rtl/stream_seq.sv
module stream_seq
    import pstream_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [PROF_W-1:0] wr_prof,
    input  logic              wr_bcast,
    input  logic              wr_load,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              ent_valid,
    output logic              busy,
    output logic [PROF_W-1:0] prof_q,
    output logic              bcast_q,
    output logic [CH_W-1:0]   ch_q,
    output logic [ENT_W-1:0]  idx
);
    seq_state_t state;

    assign busy = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            prof_q  <= '0;
            bcast_q <= 1'b0;
            ch_q    <= '0;
            idx     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ctrl_wr) begin
                        prof_q  <= wr_prof;
                        bcast_q <= wr_bcast;
                        if (wr_load) begin
                            state <= ST_RUN;
                            ch_q  <= wr_ch;
                            idx   <= '0;
                        end
                    end
                end
                ST_RUN: begin
                    if (ent_valid) idx <= idx + 1'b1;
                    else           state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_wr && wr_load) |=> busy);
    // R3
    end_on_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !ent_valid) |=> !busy);
    // R8
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(prof_q) && $stable(bcast_q) && $stable(ch_q)));
    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx <= ENT_W'(MAX_ENT)));
endmodule

// File: rtl/target_bank.sv
module target_bank
    import pstream_pkg::*;
#(
    parameter int BANK_CH = NUM_CH,
    parameter int DEPTH   = TGT_DEPTH,
    localparam int BCH_W  = $clog2(BANK_CH),
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [BCH_W-1:0]  host_ch,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              strm_en,
    input  logic              strm_bcast,
    input  logic [BCH_W-1:0]  strm_ch,
    input  logic [ADDR_W-1:0] strm_addr,
    input  logic [DATA_W-1:0] strm_mask,
    input  logic [DATA_W-1:0] strm_val
);
    logic [DATA_W-1:0] rd_arr [BANK_CH];

    for (genvar c = 0; c < BANK_CH; c++) begin : g_ch
        logic [DATA_W-1:0] mem [DEPTH];
        logic hit_s;
        logic hit_h;
        assign hit_s = strm_en && (strm_bcast || (strm_ch == BCH_W'(c)));
        assign hit_h = host_we && (host_ch == BCH_W'(c));
        assign rd_arr[c] = mem[host_addr[AW-1:0]];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int r = 0; r < DEPTH; r++) mem[r] <= 8'h55 ^ DATA_W'(r);
            end else if (hit_s) begin
                mem[strm_addr[AW-1:0]] <= (mem[strm_addr[AW-1:0]] & ~strm_mask)
                                        | (strm_val & strm_mask);
            end else if (hit_h) begin
                mem[host_addr[AW-1:0]] <= host_wdata;
            end
        end
    end

    assign host_rdata = rd_arr[host_ch];

    // R9
    no_host_in_stream_chk: assert property (@(posedge clk) disable iff (rst)
        strm_en |-> !host_we);
    // R5
    strm_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        strm_en |-> (int'(strm_addr) < DEPTH));
    // R11
    host_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        host_we |-> (int'(host_addr) < DEPTH));
endmodule

// File: rtl/prof_streamer.sv
module prof_streamer
    import pstream_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [CH_W-1:0]   host_ch,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_waitreq
);
    logic              is_ctrl, is_stat, is_tgt;
    logic              busy, bcast_q;
    logic [PROF_W-1:0] prof_q;
    logic [CH_W-1:0]   ch_q;
    logic [ENT_W-1:0]  idx;
    entry_t            ent;
    logic [DATA_W-1:0] tgt_rdata;

    assign is_ctrl = (host_addr == CTRL_ADDR);
    assign is_stat = (host_addr == STAT_ADDR);
    assign is_tgt  = (int'(host_addr) < TGT_DEPTH);
    assign host_waitreq = busy && (host_rd || host_wr) && is_tgt;

    stream_seq u_seq (
        .clk(clk), .rst(rst),
        .ctrl_wr(host_wr && is_ctrl),
        .wr_prof(host_wdata[PROF_W-1:0]),
        .wr_bcast(host_wdata[BCAST_BIT]),
        .wr_load(host_wdata[LOAD_BIT]),
        .wr_ch(host_ch),
        .ent_valid(ent.valid),
        .busy(busy), .prof_q(prof_q), .bcast_q(bcast_q), .ch_q(ch_q), .idx(idx)
    );

    profile_rom #(.DEPTH(TGT_DEPTH)) u_rom (
        .prof(prof_q), .idx(idx), .entry(ent)
    );

    target_bank #(.BANK_CH(NUM_CH), .DEPTH(TGT_DEPTH)) u_bank (
        .clk(clk), .rst(rst),
        .host_we(host_wr && is_tgt && !busy),
        .host_ch(host_ch), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(tgt_rdata),
        .strm_en(busy && ent.valid), .strm_bcast(bcast_q), .strm_ch(ch_q),
        .strm_addr(ent.addr), .strm_mask(ent.mask), .strm_val(ent.val)
    );

    always_comb begin
        host_rdata = '0;
        if (is_ctrl) begin
            host_rdata[PROF_W-1:0] = prof_q;
            host_rdata[BCAST_BIT]  = bcast_q;
        end else if (is_stat) begin
            host_rdata[0] = busy;
        end else if (is_tgt) begin
            host_rdata = tgt_rdata;
        end
    end

    // R9
    ctrl_served_chk: assert property (@(posedge clk) disable iff (rst)
        ((host_rd || host_wr) && (is_ctrl || is_stat)) |-> !host_waitreq);
endmodule

// File: tb/prof_streamer_tb_top.sv
module prof_streamer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wd = '0;
    logic [1:0] ch = '0;
    logic [7:0] rdata;
    logic       waitreq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prof_streamer dut_i (
        .clk(clk), .rst(rst), .host_addr(addr), .host_rd(rd), .host_wr(wr),
        .host_wdata(wd), .host_ch(ch), .host_rdata(rdata), .host_waitreq(waitreq)
    );

    function automatic bit b_valid(int p, int e); return e < p; endfunction
    function automatic int b_addr(int p, int e); return (5*p + 7*e) % 64; endfunction
    function automatic logic [7:0] b_mask(int e); return (e % 2 == 1) ? 8'hF0 : 8'h3C; endfunction
    function automatic logic [7:0] b_val(int p, int e);
        return 8'((16*p + 3*e + 1) % 256) ^ 8'hA5;
    endfunction
    function automatic logic [7:0] merge(logic [7:0] o, logic [7:0] m, logic [7:0] v);
        return (o & ~m) | (v & m);
    endfunction

    // Behavioural reference model
    logic [7:0] m_mem [4][64];
    bit         m_busy, m_bcast;
    int         m_prof, m_idx, m_ch;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 64; r++) m_mem[c][r] = 8'h55 ^ 8'(r);
            m_busy = 0; m_bcast = 0; m_prof = 0; m_idx = 0; m_ch = 0;
        end else if (m_busy) begin
            if (b_valid(m_prof, m_idx)) begin
                for (int c = 0; c < 4; c++)
                    if (m_bcast || c == m_ch)
                        m_mem[c][b_addr(m_prof, m_idx)] =
                            merge(m_mem[c][b_addr(m_prof, m_idx)], b_mask(m_idx), b_val(m_prof, m_idx));
                m_idx++;
            end else m_busy = 0;
        end else begin
            if (wr && addr == 10'h340) begin
                m_prof = int'(wd[2:0]);
                m_bcast = wd[6];
                if (wd[7]) begin m_busy = 1; m_idx = 0; m_ch = int'(ch); end
            end
            if (wr && addr < 10'd64) m_mem[int'(ch)][int'(addr)] = wd;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            logic exp_w;
            logic [7:0] exp_d;
            exp_w = m_busy && (rd || wr) && (addr < 10'd64);
            n_chk++;
            if (waitreq !== exp_w) begin
                n_fail++;
                $display("FAIL R9 waitreq actual=%b expected=%b addr=%h", waitreq, exp_w, addr);
            end
            if (rd && !exp_w) begin
                if (addr == 10'h340) exp_d = {1'b0, m_bcast, 3'b0, 3'(m_prof)};
                else if (addr == 10'h341) exp_d = {7'b0, m_busy};
                else if (addr < 10'd64) exp_d = m_mem[int'(ch)][int'(addr)];
                else exp_d = 8'h00;
                n_chk++;
                if (rdata !== exp_d) begin
                    n_fail++;
                    $display("FAIL R10 model rdata actual=%h expected=%h addr=%h", rdata, exp_d, addr);
                end
            end
        end
    end

    task automatic do_write(input logic [9:0] a, input logic [7:0] d, input logic [1:0] c);
        addr = a; wd = d; ch = c; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic read_chk(input logic [9:0] a, input logic [1:0] c,
                            input logic [7:0] exp, input string tag);
        addr = a; ch = c; rd = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h ch=%0d actual=%h expected=%h", tag, a, c, rdata, exp);
        end
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic poll_done();
        int n = 0;
        logic b;
        do begin
            addr = 10'h341; rd = 1'b1;
            @(negedge clk);
            b = rdata[0];
            @(posedge clk); #1;
            rd = 1'b0;
            n++;
        end while (b && n < 50);
        n_chk++;
        if (b) begin
            n_fail++;
            $display("FAIL R3 busy never cleared actual=1 expected=0");
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        read_chk(10'h341, 2'd0, 8'h00, "R1 status");
        read_chk(10'h340, 2'd0, 8'h00, "R1 control");
        read_chk(10'd9, 2'd2, 8'h55 ^ 8'd9, "R1 target");

        // R10 idle host access
        do_write(10'd3, 8'h12, 2'd1);
        read_chk(10'd3, 2'd1, 8'h12, "R10 written");
        read_chk(10'd3, 2'd0, 8'h56, "R10 other channel");

        // R2 control without load; R11 unmapped
        do_write(10'h340, 8'h46, 2'd0);
        read_chk(10'h340, 2'd0, 8'h46, "R2 control readback");
        read_chk(10'h341, 2'd0, 8'h00, "R3 no load no start");
        do_write(10'h100, 8'hFF, 2'd0);
        read_chk(10'h100, 2'd0, 8'h00, "R11 unmapped");

        // R3 / R8 / R6: profile 3 on channel 1, no broadcast
        do_write(10'h340, 8'h83, 2'd1);
        read_chk(10'h341, 2'd0, 8'h01, "R3 busy set");
        do_write(10'h340, 8'hC5, 2'd2);
        poll_done();
        read_chk(10'h340, 2'd0, 8'h03, "R8 control unchanged, R2 load reads 0");
        for (int e = 0; e < 3; e++) begin
            read_chk(10'(b_addr(3, e)), 2'd1,
                     merge(8'h55 ^ 8'(b_addr(3, e)), b_mask(e), b_val(3, e)), "R4 R5 ch1 update");
            read_chk(10'(b_addr(3, e)), 2'd0, 8'h55 ^ 8'(b_addr(3, e)), "R6 ch0 untouched");
            read_chk(10'(b_addr(3, e)), 2'd2, 8'h55 ^ 8'(b_addr(3, e)), "R6 ch2 untouched");
        end

        // R7: broadcast profile 5
        do_write(10'h340, 8'hC5, 2'd0);
        poll_done();
        for (int e = 0; e < 5; e++)
            for (int c = 0; c < 4; c++)
                read_chk(10'(b_addr(5, e)), 2'(c),
                         merge(8'h55 ^ 8'(b_addr(5, e)), b_mask(e), b_val(5, e)), "R7 broadcast");

        // R9: held-off access during profile 7 on channel 3
        do_write(10'h340, 8'h87, 2'd3);
        addr = 10'd0; wd = 8'hEE; ch = 2'd3; wr = 1'b1;
        @(negedge clk);
        n_chk++;
        if (waitreq !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 write waitreq actual=%b expected=1", waitreq);
        end
        @(posedge clk); #1;
        wr = 1'b0;
        read_chk(10'h340, 2'd0, 8'h07, "R9 control served while busy");
        poll_done();
        read_chk(10'd0, 2'd3, 8'h55, "R9 held-off write dropped");
        read_chk(10'(b_addr(7, 6)), 2'd3,
                 merge(8'h55 ^ 8'(b_addr(7, 6)), b_mask(6), b_val(7, 6)), "R5 last entry");

        // R3: empty profile 0 is busy for one cycle
        do_write(10'h340, 8'h80, 2'd0);
        read_chk(10'h341, 2'd0, 8'h01, "R3 empty busy");
        read_chk(10'h341, 2'd0, 8'h00, "R3 empty done");

        repeat (2) @(posedge clk);
        finish_up();
    end
endmodule